// File: doc/BRIEF.md
# Mixed-Sensitivity Prioritized Interrupt Controller

This block gathers thirteen interrupt requests, six from active-low external pins and seven from on-chip peripherals, and presents the most urgent one to a processor core. Each request is handled according to its sensitivity. One external pin is always falling-edge sensitive, two are always low-level sensitive, and three are set to edge or level by software. Internal peripheral requests are one-cycle active-high pulses that are latched. All external pins pass through a two-flop synchronizer before any detection.

A mode bit decides which of two source pairs is visible. In mode 0 the two fixed-level pins are visible and the two serial-port-1 requests are hidden. In mode 1 the reverse holds. Eleven sources are therefore live at any time. Each source has an enable bit.

The core sees a valid flag and a 4-bit vector that names the lowest-numbered enabled pending source. The core pulses an acknowledge to retire a latched request. Software reaches the masks, the configuration and the latches through a four-word write/read port. The latches can be forced set or cleared from that port.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, all enables are 0 and all latches are clear. Mode is 0, all configurable pins are in level mode, and `irq_valid` is 0.
- R2: A fixed-level pin (`ext_irq_n[1]` as source 1, `ext_irq_n[2]` as source 2) is pending while it is low. Pending appears two clocks after the pin goes low and disappears two clocks after it goes high. Nothing is remembered after release.
- R3: A falling edge on `ext_irq_n[0]` (source 8) sets that source's latch three clocks later. The latch stays set after the pin returns high.
- R4: Configurable pins `ext_irq_n[3..5]` are sources 5, 6 and 7. Register 1 bits 0..2 select their sensitivity: 1 means falling-edge latched, 0 means low-level. In level mode the latch is held clear.
- R5: Internal request pulses are latched on the clock edge where they are high. Source numbers are: power-down 0, serial-1 receive 3, serial-1 transmit 4, serial-0 transmit 9, serial-0 receive 10, byte-DMA 11, timer 12.
- R6: Register 1 bit 3 is the mode bit. With mode 0, sources 3 and 4 are hidden. With mode 1, sources 1 and 2 are hidden. A hidden source is never presented, is never latched, and its latch is cleared.
- R7: Register 0 bits 12..0 are the per-source enables. A pending source whose enable is 0 is not presented, but it stays pending.
- R8: `irq_valid` is 1 when any visible, enabled source is pending. `irq_vec` is then the lowest such source number.
- R9: Writing 1s to register 2 sets the matching latches. Writing 1s to register 3 clears them. Bits for sources currently in level mode or hidden are ignored.
- R10: `irq_ack` while `irq_valid` is high clears the latch of the presented source at that clock edge. It has no effect on a level-mode source.
- R11: Reads are combinational from `reg_addr`. Register 0 returns the enables. Register 1 returns {mode, edge selects}. Register 2 returns the visible pending set before masking. Register 3 returns the enabled pending set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low, asynchronous |
| ext_irq_n | input | 6 | External interrupt pins, active low, asynchronous |
| pwrdn_req | input | 1 | Power-down request pulse |
| timer_req | input | 1 | Interval timer request pulse |
| sp0_tx_req | input | 1 | Serial port 0 transmit request pulse |
| sp0_rx_req | input | 1 | Serial port 0 receive request pulse |
| sp1_tx_req | input | 1 | Serial port 1 transmit request pulse |
| sp1_rx_req | input | 1 | Serial port 1 receive request pulse |
| bdma_req | input | 1 | Byte-DMA request pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data |
| irq_ack | input | 1 | Core acknowledge of the presented vector |
| irq_valid | output | 1 | A request is presented |
| irq_vec | output | 4 | Number of the presented source |

## Verification
The assertions assume that the core raises `irq_ack` only while `irq_valid` is high. One assertion checks this assumption. The bench issues every acknowledge only after it has seen a valid vector.

The assertions also assume that internal requests arrive as pulses. The bench drives each one for exactly one clock. External pins are held steady for several clocks so the synchronizer always sees a clean level.

Register writes are issued one at a time, on the opposite edge of the clock from the one that samples them. Each write is separated from acknowledges, so the assertion on latch retirement does not have to untangle a simultaneous set and clear.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NEXT = 6,
  parameter int DW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NEXT-1:0] ext_irq_n,
  input  logic          pwrdn_req,
  input  logic          timer_req,
  input  logic          sp0_tx_req,
  input  logic          sp0_rx_req,
  input  logic          sp1_tx_req,
  input  logic          sp1_rx_req,
  input  logic          bdma_req,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          irq_ack,
  output logic          irq_valid,
  output logic [3:0]    irq_vec
);
  localparam int NSRC = 13;
  localparam int NCFG = 3;

  logic [NEXT-1:0] s1_q, s2_q, s3_q;
  logic [NEXT-1:0] fall, low;
  logic [NCFG-1:0] cfg_edge_q;
  logic            mode_q;
  logic [NSRC-1:0] en_q, pend_q, pend_d;
  logic [NSRC-1:0] evt, lvl, is_lvl, visible, latch_ok;
  logic [NSRC-1:0] set_w, clr_w, ack_bits, req, act;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_q <= '1;
      s2_q <= '1;
      s3_q <= '1;
    end else begin
      s1_q <= ext_irq_n;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end

  assign fall = s3_q & ~s2_q;
  assign low  = ~s2_q;

  assign evt = {timer_req, bdma_req, sp0_rx_req, sp0_tx_req, fall[0],
                fall[5], fall[4], fall[3], sp1_tx_req, sp1_rx_req,
                1'b0, 1'b0, pwrdn_req};
  assign lvl = {5'b0, low[5], low[4], low[3], 2'b0, low[2], low[1], 1'b0};
  assign is_lvl = {5'b0, ~cfg_edge_q, 2'b0, 2'b11, 1'b0};
  assign visible = mode_q ? 13'h1FF9 : 13'h1FE7;
  assign latch_ok = visible & ~is_lvl;

  assign set_w = (reg_wr && reg_addr == 2'd2) ? reg_wdata[NSRC-1:0] : '0;
  assign clr_w = (reg_wr && reg_addr == 2'd3) ? reg_wdata[NSRC-1:0] : '0;
  assign ack_bits = (irq_ack && irq_valid) ? (NSRC'(1) << irq_vec) : '0;

  assign pend_d = ((pend_q & ~clr_w & ~ack_bits) | evt | set_w) & latch_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q       <= '0;
      cfg_edge_q <= '0;
      mode_q     <= 1'b0;
      pend_q     <= '0;
    end else begin
      pend_q <= pend_d;
      if (reg_wr && reg_addr == 2'd0) en_q <= reg_wdata[NSRC-1:0];
      if (reg_wr && reg_addr == 2'd1) begin
        cfg_edge_q <= reg_wdata[NCFG-1:0];
        mode_q     <= reg_wdata[NCFG];
      end
    end

  assign req = (pend_q | (lvl & is_lvl)) & visible;
  assign act = req & en_q;

  always_comb begin
    irq_valid = 1'b0;
    irq_vec   = 4'd0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (act[i]) begin
        irq_valid = 1'b1;
        irq_vec   = 4'(i);
      end
  end

  always_comb
    case (reg_addr)
      2'd0:    reg_rdata = DW'(en_q);
      2'd1:    reg_rdata = DW'({mode_q, cfg_edge_q});
      2'd2:    reg_rdata = DW'(req);
      default: reg_rdata = DW'(act);
    endcase

  AST_ACK_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> irq_valid); // R10
  AST_VEC_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vec < 4'd13 && en_q[irq_vec])); // R7
  AST_VEC_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> visible[irq_vec]); // R6
  AST_NO_LOWER_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (act & ((NSRC'(1) << irq_vec) - NSRC'(1))) == '0); // R8
  AST_LEVEL_NOT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & is_lvl) == '0); // R4
  AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_valid && !is_lvl[irq_vec] && !evt[irq_vec] && !reg_wr)
      |=> !pend_q[$past(irq_vec)]); // R10
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] ext_irq_n = '1;
  logic pwrdn_req = 0, timer_req = 0, sp0_tx_req = 0, sp0_rx_req = 0;
  logic sp1_tx_req = 0, sp1_rx_req = 0, bdma_req = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic irq_ack = 0;
  logic irq_valid;
  logic [3:0] irq_vec;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  irq_prio_ctrl u_dut (.clk, .rst_n, .ext_irq_n, .pwrdn_req, .timer_req,
    .sp0_tx_req, .sp0_rx_req, .sp1_tx_req, .sp1_rx_req, .bdma_req,
    .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .irq_ack, .irq_valid, .irq_vec);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string r, logic [15:0] a, logic [15:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, a, e);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic chk_out(string r, logic v, logic [3:0] vec);
    chk({r, " valid"}, 16'(irq_valid), 16'(v));
    if (v) chk({r, " vec"}, 16'(irq_vec), 16'(vec));
  endtask

  task automatic ack;
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1;
    @(negedge clk); sig = 0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk_out("R1", 0, 0);
    rd(0, d); chk("R1 enables", d, 0);
    rd(1, d); chk("R1 config", d, 0);
    rd(2, d); chk("R1 pending", d, 0);
    wr(0, 16'h1FFF);
    rd(0, d); chk("R11 enable readback", d, 16'h1FFF);
  endtask

  task automatic t_level;
    @(negedge clk); ext_irq_n[1] = 0;
    cyc(1); chk_out("R2 not yet", 0, 0);
    cyc(1); chk_out("R2 low pending", 1, 1);
    ext_irq_n[1] = 1;
    cyc(2); chk_out("R2 released", 0, 0);
  endtask

  task automatic t_edge;
    @(negedge clk); ext_irq_n[0] = 0;
    cyc(2); chk_out("R3 before latch", 0, 0);
    cyc(1); chk_out("R3 latched", 1, 8);
    ext_irq_n[0] = 1;
    cyc(4); chk_out("R3 held after release", 1, 8);
    ack; chk_out("R10 ack clears", 0, 0);
  endtask

  task automatic t_cfg;
    logic [15:0] d;
    wr(1, 16'h0001);
    rd(1, d); chk("R11 config readback", d, 16'h0001);
    @(negedge clk); ext_irq_n[3] = 0;
    cyc(3); ext_irq_n[3] = 1;
    cyc(3); chk_out("R4 edge mode latched", 1, 5);
    ack; chk_out("R4 edge acked", 0, 0);
    wr(1, 16'h0000);
    @(negedge clk); ext_irq_n[3] = 0;
    cyc(2); chk_out("R4 level mode", 1, 5);
    ext_irq_n[3] = 1;
    cyc(2); chk_out("R4 level released", 0, 0);
  endtask

  task automatic t_internal;
    pulse(timer_req); chk_out("R5 timer", 1, 12);
    pulse(pwrdn_req); chk_out("R8 power-down wins", 1, 0);
    ack; chk_out("R8 next is timer", 1, 12);
    pulse(bdma_req); chk_out("R8 bdma over timer", 1, 11);
    ack; ack; chk_out("R5 all retired", 0, 0);
  endtask

  task automatic t_mode;
    logic [15:0] d;
    pulse(sp1_rx_req);
    rd(2, d); chk("R6 hidden not latched", d, 0);
    @(negedge clk); ext_irq_n[2] = 0;
    cyc(2); chk_out("R6 mode0 pin visible", 1, 2);
    wr(1, 16'h0008);
    chk_out("R6 mode1 pin hidden", 0, 0);
    pulse(sp1_tx_req); chk_out("R6 mode1 serial visible", 1, 4);
    wr(1, 16'h0000);
    rd(2, d); chk("R6 hidden latch cleared", d, 16'h0004);
    ext_irq_n[2] = 1;
    cyc(2); chk_out("R6 idle", 0, 0);
  endtask

  task automatic t_mask;
    logic [15:0] d;
    wr(0, 16'h0FFF);
    pulse(timer_req); chk_out("R7 masked", 0, 0);
    rd(2, d); chk("R7 still pending", d, 16'h1000);
    rd(3, d); chk("R11 enabled pending", d, 0);
    wr(0, 16'h1FFF); chk_out("R7 unmasked", 1, 12);
    ack;
  endtask

  task automatic t_force;
    logic [15:0] d;
    wr(2, 16'h0200); chk_out("R9 force set", 1, 9);
    wr(2, 16'h0002);
    rd(2, d); chk("R9 level bit ignored", d, 16'h0200);
    wr(3, 16'h0200); chk_out("R9 force clear", 0, 0);
  endtask

  task automatic t_ack_level;
    @(negedge clk); ext_irq_n[1] = 0;
    cyc(2); chk_out("R10 level present", 1, 1);
    ack; chk_out("R10 ack no effect on level", 1, 1);
    ext_irq_n[1] = 1;
    cyc(2); chk_out("R10 level gone", 0, 0);
  endtask

  initial begin
    cyc(2); rst_n = 1; cyc(1);
    t_reset; t_level; t_edge; t_cfg; t_internal;
    t_mode; t_mask; t_force; t_ack_level;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule